// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

The controller gathers up to 32 level-sensitive peripheral request lines and drives a single interrupt request toward a host processor. Each source has an enable bit in a mask register. Unmasked, asserted requests compete under a fixed priority in which the higher vector number wins. One source named in the configuration register may be promoted above all others. A global enable gates the host request. A configurable level code is presented beside it.

Software acknowledges in two steps. It writes the ack bit of the vector register, then reads the register back to obtain the winning vector number. The acknowledge marks that source in service. While it is in service, only strictly higher-priority sources can raise the host request again, so interrupts nest. Service ends when software writes a one to the source's bit in the in-service register.

Vector 0 is reserved as the error vector. It is reported when a source's enable is cleared in the same cycle its request rises, and when an acknowledge finds nothing eligible. Request line 0 is never used as a source.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the configuration, mask, in-service and vector registers all read zero, and `irq_o` is low.
- R2: Mask bit n (word address 1) set to 1 enables source n; an asserted request on a source whose mask bit is 0 never wins and never raises `irq_o`.
- R3: `irq_o` stays low whenever the global enable, configuration bit 7 (word address 0), is 0.
- R4: Writing a word with bit 0 set to the vector register (word address 3) is an acknowledge; reading that register returns the selected vector in bits 15:11 with all other bits zero. The value is held until the next acknowledge.
- R5: Among eligible sources the highest vector number wins, except that the source named in configuration bits 12:8 beats every other source.
- R6: An acknowledge that selects source n sets in-service bit n (word address 2); writing 1 to bit n of that register clears it, and written 0 bits leave their bits unchanged.
- R7: While any source is in service, only pending sources of strictly higher priority than the highest in-service source can raise `irq_o` or be returned by an acknowledge.
- R8: Requests are level-sensitive: a source counts as pending only while its input is high, so a request dropped before the acknowledge is not returned.
- R9: If a mask write clears bit n in the same cycle that request n rises while bit n was set, an error is latched. It raises `irq_o` when enabled and nothing is in service. The next acknowledge returns vector 0, clears the error and sets no in-service bit.
- R10: An acknowledge with no eligible source returns vector 0 and leaves the in-service register unchanged.
- R11: Configuration bits 15:13 appear unchanged on `irq_lvl_o`.
- R12: Request line 0 is ignored: raising it while mask bit 0 is set does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address: 0 config, 1 mask, 2 in-service, 3 vector |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| req_i | input | 32 | Level-sensitive source requests |
| irq_o | output | 1 | Request to the host |
| irq_lvl_o | output | 3 | Request level code for the host |

## Verification
The assertions assume that one register is written per cycle. They also assume the promotion field names a vector within the source count, and that request inputs change only between clock edges. The bench drives every input on the falling edge through single-write tasks, so a mask write and a request edge coincide only where the race scenario intends it. Promotion values are always below 32. The error-latch property assumes the race is seen only through a mask write, which is the only path the bench uses to create it.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      REG_CFG  = 2'd0,
      REG_MASK = 2'd1,
      REG_ISR  = 2'd2,
      REG_VEC  = 2'd3
   } reg_sel_e;

   localparam int CFG_W       = 16;
   localparam int CFG_EN_BIT  = 7;
   localparam int CFG_PRO_LSB = 8;
   localparam int CFG_LVL_LSB = 13;
   localparam int VEC_RD_LSB  = 11;
   localparam int ACK_BIT     = 0;
endpackage

// File: rtl/prio_resolver.sv
module prio_resolver #(
   parameter int N  = 32,
   parameter int VW = 5
) (
   input  logic [N-1:0]  req_i,
   input  logic [VW-1:0] promo_i,
   output logic          valid_o,
   output logic [VW-1:0] idx_o,
   output logic [VW:0]   rank_o
);
   always_comb begin
      logic [VW:0] r;
      valid_o = 1'b0;
      idx_o   = '0;
      rank_o  = '0;
      for (int n = 0; n < N; n++) begin
         r = (VW'(n) == promo_i) ? {1'b1, {VW{1'b0}}} : {1'b0, VW'(n)};
         if (req_i[n] && (!valid_o || r > rank_o)) begin
            valid_o = 1'b1;
            idx_o   = VW'(n);
            rank_o  = r;
         end
      end
   end
endmodule

// File: rtl/race_detect.sv
module race_detect #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] mask_q_i,
   input  logic         mask_wr_i,
   input  logic [N-1:0] mask_new_i,
   output logic         race_o
);
   logic [N-1:0] req_q;
   logic [N-1:0] hit;

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_i;
   end

   for (genvar n = 0; n < N; n++) begin : g_bit
      assign hit[n] = req_i[n] & ~req_q[n] & mask_q_i[n] & mask_wr_i & ~mask_new_i[n];
   end

   assign race_o = |hit;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [NUM_SRC-1:0] req_i,
   output logic              irq_o,
   output logic [pic_pkg::CFG_W-pic_pkg::CFG_LVL_LSB-1:0] irq_lvl_o
);
   import pic_pkg::*;

   localparam int VW    = $clog2(NUM_SRC);
   localparam int LVL_W = CFG_W - CFG_LVL_LSB;

   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_src
      $error("NUM_SRC must lie in 2..32");
   end
   if (DATA_W < NUM_SRC || DATA_W < CFG_W) begin : g_bad_data
      $error("DATA_W too narrow for the register set");
   end
   if (CFG_PRO_LSB + VW > CFG_LVL_LSB) begin : g_bad_pro
      $error("promotion field overlaps level field");
   end

   logic [CFG_W-1:0]   cfg_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] isr_q;
   logic [NUM_SRC-1:0] isr_d;
   logic [VW-1:0]      vec_q;
   logic               err_pend;

   logic               cfg_en;
   logic [VW-1:0]      promo;
   logic               ack;
   logic               mask_wr;
   logic               isr_wr;
   logic [NUM_SRC-1:0] req_eff;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] elig;

   logic               win_valid;
   logic [VW-1:0]      win_idx;
   logic [VW:0]        win_rank;
   logic               isr_valid;
   logic [VW-1:0]      isr_top_idx;
   logic [VW:0]        isr_rank;
   logic               race_hit;

   assign cfg_en  = cfg_q[CFG_EN_BIT];
   assign promo   = cfg_q[CFG_PRO_LSB +: VW];
   assign mask_wr = wr_en_i && (addr_i == REG_MASK);
   assign isr_wr  = wr_en_i && (addr_i == REG_ISR);
   assign ack     = wr_en_i && (addr_i == REG_VEC) && wdata_i[ACK_BIT];

   // line 0 carries no source: vector 0 is the error vector
   assign req_eff = req_i & ~NUM_SRC'(1);
   assign pend    = req_eff & mask_q;

   prio_resolver #(.N(NUM_SRC), .VW(VW)) u_isr_top (
      .req_i   (isr_q),
      .promo_i (promo),
      .valid_o (isr_valid),
      .idx_o   (isr_top_idx),
      .rank_o  (isr_rank)
   );

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_elig
      logic [VW:0] rank_n;
      assign rank_n  = (VW'(n) == promo) ? {1'b1, {VW{1'b0}}} : {1'b0, VW'(n)};
      assign elig[n] = pend[n] & (!isr_valid || rank_n > isr_rank);
   end

   prio_resolver #(.N(NUM_SRC), .VW(VW)) u_win (
      .req_i   (elig),
      .promo_i (promo),
      .valid_o (win_valid),
      .idx_o   (win_idx),
      .rank_o  (win_rank)
   );

   race_detect #(.N(NUM_SRC)) u_race (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_eff),
      .mask_q_i   (mask_q),
      .mask_wr_i  (mask_wr),
      .mask_new_i (wdata_i[NUM_SRC-1:0]),
      .race_o     (race_hit)
   );

   always_comb begin
      isr_d = isr_q;
      if (isr_wr)            isr_d = isr_d & ~wdata_i[NUM_SRC-1:0];
      if (ack && win_valid)  isr_d = isr_d | (NUM_SRC'(1) << win_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         mask_q   <= '0;
         isr_q    <= '0;
         vec_q    <= '0;
         err_pend <= 1'b0;
      end else begin
         isr_q <= isr_d;
         if (wr_en_i && addr_i == REG_CFG) cfg_q  <= wdata_i[CFG_W-1:0];
         if (mask_wr)                      mask_q <= wdata_i[NUM_SRC-1:0];
         if (ack) vec_q <= win_valid ? win_idx : '0;
         if (race_hit)                err_pend <= 1'b1;
         else if (ack && !win_valid)  err_pend <= 1'b0;
      end
   end

   always_comb begin
      case (reg_sel_e'(addr_i))
         REG_CFG:  rdata_o = DATA_W'(cfg_q);
         REG_MASK: rdata_o = DATA_W'(mask_q);
         REG_ISR:  rdata_o = DATA_W'(isr_q);
         default:  rdata_o = DATA_W'(vec_q) << VEC_RD_LSB;
      endcase
   end

   assign irq_o     = cfg_en && (win_valid || (err_pend && !isr_valid));
   assign irq_lvl_o = cfg_q[CFG_LVL_LSB +: LVL_W];
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32,
   parameter int VW      = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en_i,
   input logic [1:0]         addr_i,
   input logic [DATA_W-1:0]  wdata_i,
   input logic               irq_o,
   input logic               cfg_en,
   input logic [NUM_SRC-1:0] mask_q,
   input logic [NUM_SRC-1:0] isr_q,
   input logic [VW-1:0]      vec_q,
   input logic               err_pend,
   input logic               win_valid,
   input logic [VW-1:0]      win_idx,
   input logic               isr_valid,
   input logic [VW-1:0]      isr_top_idx,
   input logic               race_hit
);
   logic ack_c;
   assign ack_c = wr_en_i && addr_i == 2'd3 && wdata_i[0];

   assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |-> !irq_o);

   assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && addr_i == 2'd1) |=> $stable(mask_q));

   assert_vec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_c |=> $stable(vec_q));

   assert_ack_sets_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_c && win_valid) |=> (isr_q[$past(win_idx)] && vec_q == $past(win_idx)));

   assert_isr_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == 2'd2) |=> isr_q == ($past(isr_q) & ~$past(wdata_i[NUM_SRC-1:0])));

   assert_empty_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_c && !win_valid) |=> (vec_q == '0 && !err_pend && isr_q == $past(isr_q)));

   assert_race_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      race_hit |=> err_pend);

   assert_isr_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      isr_valid |-> isr_q[isr_top_idx]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .VW(VW)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en_i     (wr_en_i),
   .addr_i      (addr_i),
   .wdata_i     (wdata_i),
   .irq_o       (irq_o),
   .cfg_en      (cfg_en),
   .mask_q      (mask_q),
   .isr_q       (isr_q),
   .vec_q       (vec_q),
   .err_pend    (err_pend),
   .win_valid   (win_valid),
   .win_idx     (win_idx),
   .isr_valid   (isr_valid),
   .isr_top_idx (isr_top_idx),
   .race_hit    (race_hit)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] EN = 32'h80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic [31:0] req_i = '0;
   logic        irq_o;
   logic [2:0]  irq_lvl_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .req_i(req_i),
      .irq_o(irq_o), .irq_lvl_o(irq_lvl_o)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      wr_en_i = 1'b0; wdata_i = '0;
      #1;
   endtask

   task automatic bus_rd(logic [1:0] a, output logic [31:0] d);
      addr_i = a;
      #1;
      d = rdata_o;
   endtask

   task automatic ack_and_read(output logic [31:0] v);
      bus_wr(2'd3, 32'h1);
      bus_rd(2'd3, v);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int a = 0; a < 4; a++) begin
         bus_rd(a[1:0], d);
         check($sformatf("R1 reg %0d after reset", a), d, 0);
      end
      check("R1 irq low after reset", {31'b0, irq_o}, 0);
   endtask

   task automatic t_enable_mask;
      logic [31:0] v;
      bus_wr(2'd1, 32'h20);
      req_i = 32'h220;
      #1;
      check("R3 irq low while disabled", {31'b0, irq_o}, 0);
      bus_wr(2'd0, EN | (32'd3 << 13));
      check("R3 irq high once enabled", {31'b0, irq_o}, 1);
      check("R11 level code", {29'b0, irq_lvl_o}, 3);
      ack_and_read(v);
      check("R2 masked source 9 loses to 5", v, 32'd5 << 11);
      bus_wr(2'd2, 32'h20);
      req_i = '0;
      bus_wr(2'd1, 32'h0);
   endtask

   task automatic t_priority;
      logic [31:0] v;
      bus_wr(2'd1, (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 20));
      req_i = (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 20);
      ack_and_read(v);
      check("R5 highest number wins", v, 32'd20 << 11);
      bus_rd(2'd2, v);
      check("R6 ack sets in-service bit", v, 32'h1 << 20);
      bus_wr(2'd2, 32'h0);
      bus_rd(2'd2, v);
      check("R6 zero write leaves in-service", v, 32'h1 << 20);
      bus_rd(2'd3, v);
      check("R4 vector held without new ack", v, 32'd20 << 11);
      bus_wr(2'd2, 32'h1 << 20);
      bus_rd(2'd2, v);
      check("R6 one write clears in-service", v, 0);
      bus_wr(2'd0, EN | (32'd5 << 8));
      ack_and_read(v);
      check("R5 promoted source 5 wins", v, 32'd5 << 11);
      bus_wr(2'd2, 32'h1 << 5);
      bus_wr(2'd0, EN);
      req_i = '0;
   endtask

   task automatic t_nesting;
      logic [31:0] v;
      bus_wr(2'd1, (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 20));
      req_i = (32'h1 << 5) | (32'h1 << 9);
      ack_and_read(v);
      check("R7 first ack returns 9", v, 32'd9 << 11);
      check("R7 lower source blocked while 9 in service", {31'b0, irq_o}, 0);
      ack_and_read(v);
      check("R10 ack with nothing eligible returns 0", v, 0);
      bus_rd(2'd2, v);
      check("R10 in-service untouched", v, 32'h1 << 9);
      @(negedge clk);
      req_i = req_i | (32'h1 << 20);
      #1;
      check("R7 higher source nests", {31'b0, irq_o}, 1);
      ack_and_read(v);
      check("R7 nested ack returns 20", v, 32'd20 << 11);
      bus_rd(2'd2, v);
      check("R7 both in service", v, (32'h1 << 9) | (32'h1 << 20));
      bus_wr(2'd2, (32'h1 << 9) | (32'h1 << 20));
      check("R7 lower source free after clear", {31'b0, irq_o}, 1);
      req_i = '0;
      bus_wr(2'd1, 32'h0);
   endtask

   task automatic t_level;
      logic [31:0] v;
      bus_wr(2'd1, 32'h1 << 12);
      req_i = 32'h1 << 12;
      #1;
      check("R8 level request raises irq", {31'b0, irq_o}, 1);
      @(negedge clk);
      req_i = '0;
      #1;
      check("R8 dropped request clears irq", {31'b0, irq_o}, 0);
      ack_and_read(v);
      check("R8 dropped request not returned", v, 0);
      bus_wr(2'd1, 32'h0);
   endtask

   task automatic t_race;
      logic [31:0] v;
      bus_wr(2'd1, 32'h1 << 7);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = 2'd1; wdata_i = 32'h0;
      req_i = 32'h1 << 7;
      @(negedge clk);
      wr_en_i = 1'b0;
      #1;
      check("R9 race raises irq", {31'b0, irq_o}, 1);
      ack_and_read(v);
      check("R9 race returns error vector", v, 0);
      check("R9 error cleared by ack", {31'b0, irq_o}, 0);
      bus_rd(2'd2, v);
      check("R9 no in-service bit for error", v, 0);
      req_i = '0;
   endtask

   task automatic t_line0;
      bus_wr(2'd1, 32'h1);
      req_i = 32'h1;
      #1;
      check("R12 line 0 ignored", {31'b0, irq_o}, 0);
      req_i = '0;
      bus_wr(2'd1, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_enable_mask();
      t_priority();
      t_nesting();
      t_level();
      t_race();
      t_line0();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule